// File: doc/BRIEF.md
# Host Command/Reply Queue Port

This block is the device-side register window through which a host and a storage controller swap command descriptors. The host posts the bus address of each command list by writing it to a request register. The address goes into a request queue, and the device's local logic drains that queue through a valid/ready handshake. When the device has finished a command, it pushes the address into a reply queue through a second handshake. The host reads that address back from a reply register.

The signalling is inverted from the usual convention:

- A request-register read of zero means the request queue is full.
- A reply-register read of all ones means the reply queue is empty.
- Reading a reply does not consume it. The host consumes a reply by writing zero back to the same register.
- The interrupt is enabled by clearing a mask bit, not by setting it.

A status register reports whether a completion is waiting. It also holds a sticky flag for request writes that were dropped.

The host bus is a plain one-cycle register strobe interface with 32-bit data. The word registers are selected by bits [3:2] of the address:

| Offset | Register |
|--------|----------|
| 0x0 | Request |
| 0x4 | Reply |
| 0x8 | Mask |
| 0xC | Status |

Top module: `host_fifo_port`

## Requirements
- R1: A host write to offset 0x0 while the request queue has space enqueues the write data. Queued requests appear on `req_data` with `req_valid` high, in write order, and each is removed when `req_ready` is high in a cycle where `req_valid` is high.
- R2: A host read of offset 0x0 returns the number of free request slots (DEPTH minus occupancy). That value is zero exactly when the request queue is full.
- R3: A host read of offset 0x4 returns 32'hFFFFFFFF when the reply queue is empty, and otherwise the oldest queued reply. Reads never remove an entry, so repeated reads return the same value.
- R4: A host write of zero to offset 0x4 removes the oldest reply. A nonzero write to offset 0x4, or any write there while the reply queue is empty, changes nothing.
- R5: The mask register at offset 0x8 holds only bit 3. It resets to 32'h8 (interrupt disabled). Writing 0 enables the interrupt, writing 32'h8 disables it, and a read returns the stored value.
- R6: Status bit 0 at offset 0xC is 1 exactly when the reply queue is non-empty.
- R7: A request write while the request queue is full is dropped. It sets status bit 1, which stays set until reset.
- R8: `irq` is registered. In each cycle it equals (reply queue non-empty AND mask bit 3 clear), as evaluated at the previous clock edge.
- R9: `rsp_ready` is low exactly when the reply queue holds DEPTH entries. Completions accepted while `rsp_valid` and `rsp_ready` are both high are returned to the host in acceptance order.
- R10: Read data is registered. `host_rdata` shows the selected value in the cycle after the one in which `host_rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | 4 | Host byte offset; bits [3:2] select the register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| req_valid | output | 1 | Request queue holds an entry |
| req_data | output | 32 | Oldest request address |
| req_ready | input | 1 | Device takes the request this cycle |
| rsp_valid | input | 1 | Device offers a completion |
| rsp_data | input | 32 | Completed command address |
| rsp_ready | output | 1 | Reply queue has space |
| irq | output | 1 | Host interrupt, active high |

## Verification
The boundary cases are the hardest to reach from the ports. The request queue must reach exactly full, so that its read returns zero and one more write is dropped and flagged. The reply queue must also fill completely, so that `rsp_ready` falls. The bench reaches both states with a full sweep of posts and completions. At each step it compares the free-slot count against DEPTH minus the number already posted. It then drains each queue entry by entry and checks the values it wrote earlier, in the order it wrote them.

// File: rtl/host_fifo_pkg.sv
package host_fifo_pkg;
  localparam int DATA_W = 32;
  localparam logic [1:0] SEL_REQ  = 2'd0;
  localparam logic [1:0] SEL_RPL  = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;
  localparam int MASK_BIT = 3;
  localparam logic [DATA_W-1:0] EMPTY_CODE = '1;
endpackage

// File: rtl/cmd_queue.sv
module cmd_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/host_fifo_port.sv
module host_fifo_port #(
  parameter int REQ_DEPTH = 16,
  parameter int RPL_DEPTH = 16,
  localparam int DW       = host_fifo_pkg::DATA_W,
  localparam int RQ_CW    = $clog2(REQ_DEPTH + 1),
  localparam int RP_CW    = $clog2(RPL_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr_en,
  input  logic          host_rd_en,
  input  logic [3:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          req_valid,
  output logic [DW-1:0] req_data,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          rsp_ready,
  output logic          irq
);
  import host_fifo_pkg::*;

  logic [1:0]       sel;
  logic             req_empty, req_full, rpl_empty, rpl_full;
  logic [RQ_CW-1:0] req_count;
  logic [RP_CW-1:0] rpl_count;
  logic [DW-1:0]    rpl_head;
  logic             mask_off, ovf_flag;
  logic             req_push, rpl_pop, rpl_push;
  logic [DW-1:0]    rd_mux;

  assign sel      = host_addr[3:2];
  assign req_push = host_wr_en && (sel == SEL_REQ);
  assign rpl_pop  = host_wr_en && (sel == SEL_RPL) && (host_wdata == '0);
  assign rpl_push = rsp_valid && !rpl_full;

  cmd_queue #(.W(DW), .DEPTH(REQ_DEPTH)) u_reqq (
    .clk(clk), .rst(rst), .push(req_push), .din(host_wdata),
    .pop(req_ready), .dout(req_data), .empty(req_empty),
    .full(req_full), .count(req_count)
  );

  cmd_queue #(.W(DW), .DEPTH(RPL_DEPTH)) u_rplq (
    .clk(clk), .rst(rst), .push(rpl_push), .din(rsp_data),
    .pop(rpl_pop), .dout(rpl_head), .empty(rpl_empty),
    .full(rpl_full), .count(rpl_count)
  );

  assign req_valid = !req_empty;
  assign rsp_ready = !rpl_full;

  always_comb begin
    case (sel)
      SEL_REQ:  rd_mux = DW'(REQ_DEPTH) - DW'(req_count);
      SEL_RPL:  rd_mux = rpl_empty ? EMPTY_CODE : rpl_head;
      SEL_MASK: rd_mux = DW'(mask_off) << MASK_BIT;
      default:  rd_mux = {{(DW-2){1'b0}}, ovf_flag, !rpl_empty};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      mask_off   <= 1'b1;
      ovf_flag   <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (host_rd_en) host_rdata <= rd_mux;
      if (host_wr_en && sel == SEL_MASK) mask_off <= host_wdata[MASK_BIT];
      if (req_push && req_full) ovf_flag <= 1'b1;
      irq <= !rpl_empty && !mask_off;
    end
  end
endmodule

// File: rtl/host_fifo_port_chk.sv
module host_fifo_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_wr_en,
  input logic        host_rd_en,
  input logic [3:0]  host_addr,
  input logic [31:0] host_rdata,
  input logic        req_valid,
  input logic        req_full,
  input logic        rpl_empty,
  input logic        mask_off,
  input logic        ovf_flag,
  input logic        irq
);
  a_r1_post_visible: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && host_addr[3:2] == 2'd0 && !req_full) |=> req_valid);

  a_r2_full_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (host_rd_en && host_addr[3:2] == 2'd0 && req_full) |=> (host_rdata == 32'h0));

  a_r3_empty_all_ones: assert property (@(posedge clk) disable iff (rst)
    (host_rd_en && host_addr[3:2] == 2'd1 && rpl_empty) |=> (host_rdata == 32'hFFFF_FFFF));

  a_r7_sticky_overflow: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  a_r7_drop_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && host_addr[3:2] == 2'd0 && req_full) |=> ovf_flag);

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (!rpl_empty && !mask_off) |=> irq);

  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (rpl_empty || mask_off) |=> !irq);
endmodule

bind host_fifo_port host_fifo_port_chk u_chk (
  .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
  .host_addr(host_addr), .host_rdata(host_rdata), .req_valid(req_valid),
  .req_full(req_full), .rpl_empty(rpl_empty), .mask_off(mask_off),
  .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/tb_host_fifo_port.sv
`timescale 1ns/1ps
module tb_host_fifo_port;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [31:0] req_data;
  logic        rsp_valid = 1'b0, rsp_ready;
  logic [31:0] rsp_data = '0;
  logic        irq;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  host_fifo_port #(.REQ_DEPTH(DEPTH), .RPL_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .req_valid(req_valid), .req_data(req_data), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
    .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic hread(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rdata;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    logic [31:0] got;
    hread(a, got);
    check(got == e, tag, got, e);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    check(req_valid == 1'b0, "R1 reset req_valid", 32'(req_valid), 32'h0);
    check(irq == 1'b0, "R8 reset irq", 32'(irq), 32'h0);
    check(rsp_ready == 1'b1, "R9 reset rsp_ready", 32'(rsp_ready), 32'h1);
    expect_reg(4'h8, 32'h8, "R5 reset mask");
    expect_reg(4'hC, 32'h0, "R6 reset status");
    expect_reg(4'h4, 32'hFFFF_FFFF, "R3 empty reply");
    expect_reg(4'h0, DEPTH, "R2 reset free slots");

    // R10: read data holds until next read
    idle();
    check(host_rdata == DEPTH, "R10 rdata held", host_rdata, DEPTH);

    // Fill request queue, sweeping free-slot count
    for (int i = 0; i < DEPTH; i++) begin
      expect_reg(4'h0, 32'(DEPTH - i), "R2 free slots sweep");
      hwrite(4'h0, 32'h1000_0000 + 32'(i * 16));
    end
    expect_reg(4'h0, 32'h0, "R2 full reads zero");
    expect_reg(4'hC, 32'h0, "R7 no overflow yet");
    hwrite(4'h0, 32'hDEAD_BEEF);
    expect_reg(4'hC, 32'h2, "R7 overflow flag set");
    expect_reg(4'h0, 32'h0, "R7 dropped write left queue full");

    // Drain in order
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      check(req_valid == 1'b1, "R1 req_valid during drain", 32'(req_valid), 32'h1);
      check(req_data == 32'h1000_0000 + 32'(i * 16), "R1 request order",
            req_data, 32'h1000_0000 + 32'(i * 16));
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
    end
    check(req_valid == 1'b0, "R7 dropped value absent", 32'(req_valid), 32'h0);
    expect_reg(4'hC, 32'h2, "R7 flag sticky");
    expect_reg(4'h0, DEPTH, "R2 empty after drain");

    // Fill reply queue
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      check(rsp_ready == 1'b1, "R9 rsp_ready with space", 32'(rsp_ready), 32'h1);
      rsp_valid = 1'b1; rsp_data = 32'h2000_0000 + 32'(i * 4);
      @(negedge clk);
      rsp_valid = 1'b0;
    end
    check(rsp_ready == 1'b0, "R9 rsp_ready low when full", 32'(rsp_ready), 32'h0);
    expect_reg(4'hC, 32'h3, "R6 pending set");
    check(irq == 1'b0, "R8 masked irq", 32'(irq), 32'h0);
    hwrite(4'h8, 32'h0);
    idle();
    check(irq == 1'b1, "R8 irq after enable", 32'(irq), 32'h1);
    expect_reg(4'h8, 32'h0, "R5 mask reads zero");

    // Read, re-read, acknowledge
    for (int i = 0; i < DEPTH; i++) begin
      expect_reg(4'h4, 32'h2000_0000 + 32'(i * 4), "R9 reply order");
      expect_reg(4'h4, 32'h2000_0000 + 32'(i * 4), "R3 reread same");
      if (i == 0) begin
        hwrite(4'h4, 32'h5);
        expect_reg(4'h4, 32'h2000_0000, "R4 nonzero write ignored");
      end
      hwrite(4'h4, 32'h0);
    end
    expect_reg(4'h4, 32'hFFFF_FFFF, "R3 empty after acks");
    expect_reg(4'hC, 32'h2, "R6 pending clear");
    idle();
    check(irq == 1'b0, "R8 irq drops when empty", 32'(irq), 32'h0);
    hwrite(4'h4, 32'h0);
    expect_reg(4'h4, 32'hFFFF_FFFF, "R4 ack on empty no effect");
    check(rsp_ready == 1'b1, "R4 reply queue intact", 32'(rsp_ready), 32'h1);

    // Mask disable with pending
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = 32'hCAFE_0010;
    @(negedge clk);
    rsp_valid = 1'b0;
    idle();
    check(irq == 1'b1, "R8 irq on new completion", 32'(irq), 32'h1);
    hwrite(4'h8, 32'h8);
    idle();
    check(irq == 1'b0, "R5 disable masks irq", 32'(irq), 32'h0);
    expect_reg(4'h8, 32'h8, "R5 mask readback");
    hread(4'h4, rv);
    check(rv == 32'hCAFE_0010, "R10 registered read value", rv, 32'hCAFE_0010);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule